// File: doc/BRIEF.md
# Vectored Interrupt Controller with Mask-Write Register Interface

The controller gathers up to 32 interrupt sources into one request line for a processor. Each source has a type fixed at build time by a parameter bit: a level source sets its status bit in every cycle its input is high, and an edge source sets its status bit once, on a rising transition. Status bits are sticky. They are qualified by a per-source enable to form the pending set. The number of the lowest pending source is offered as a vector, so a handler can dispatch without scanning.

Software reaches the block through 32-bit word registers on a simple write-strobe port, with a combinational read path. Acknowledge, enable and disable are done with bit-mask writes, so no read-modify-write is needed. A two-bit master control separates hardware capture of the inputs from the driving of the request output. While capture is off, software may load the status word directly, which serves for test and for software-raised interrupts.

Top module: `irqc_top`

## Requirements
- R1: After reset, status, enable, master control and the input history are zero, `irq_out` is low and the vector word reads 32'hFFFF_FFFF.
- R2: When master bit 1 (capture) is set, a level source (SRC_KIND bit 0) sets its status bit at each clock edge where its input is high. The bit stays set after the input falls.
- R3: When capture is on, an edge source (SRC_KIND bit 1) sets its status bit only at the edge after a low-to-high change. An input held high does not set the bit again after it is acknowledged.
- R4: A write to the master word (byte address 0x1C) keeps only data bits 1:0. While bit 1 is clear, no input sets any status bit.
- R5: The pending word (0x04) always reads as status AND enable.
- R6: The vector word (0x18) reads the index of the lowest-numbered pending bit, zero-extended. With nothing pending it reads all ones.
- R7: `irq_out` is high exactly when master bit 0 is set and at least one pending bit is set.
- R8: A write to the acknowledge word (0x0C) clears every status bit whose data bit is 1. A level source whose input is still high, with capture on, is set again in the same cycle.
- R9: A write to 0x10 ORs the data into the enable word (0x08). A write to 0x14 clears every enable bit whose data bit is 1.
- R10: A write to the status word (0x00) replaces it only while master bit 1 is clear. Otherwise the write is ignored.
- R11: Reads of 0x0C, 0x10, 0x14 and of any word index above 7 return zero. A write has effect only if `wr_be` is 4'hF, `addr[1:0]` is zero and the word index is at most 7.
- R12: Pending, vector and `irq_out` follow the registered state, so a register write shows on them after the next clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Interrupt source inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_be | input | 4 | Byte enables; only 4'hF writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq_out | output | 1 | Interrupt request |

## Verification
Assertions run on every cycle. They check that an acknowledge with capture off leaves the masked bits clear, and that set-enable and clear-enable leave exactly the requested bits set or cleared. They check that the master word keeps the written low two bits, that status never gains bits while capture is off unless software writes it, and that with capture on every new status bit comes from the capture logic. They also check that the encoder's vector names a pending bit with no lower pending bit, and that the request is high only when something is pending. The scenarios alone show the behaviour that depends on source type and history: an edge source that is not raised again while its input stays high, a level source that survives its own acknowledge, stickiness after an input falls, the zero reads, and writes dropped for partial strobes, misalignment or unmapped addresses. They also show the one-cycle delay from a write to the request output.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

    // Word index of each register; byte address is index * 4.
    typedef enum logic [2:0] {
        RI_STATUS = 3'd0,
        RI_PEND   = 3'd1,
        RI_ENABLE = 3'd2,
        RI_ACK    = 3'd3,
        RI_SETEN  = 3'd4,
        RI_CLREN  = 3'd5,
        RI_VECTOR = 3'd6,
        RI_MASTER = 3'd7
    } reg_idx_e;

    localparam int unsigned NUM_WORDS     = 8;
    localparam int unsigned MASTER_W      = 2;
    localparam int unsigned MSTR_OUT_BIT  = 0;
    localparam int unsigned MSTR_CAP_BIT  = 1;
    localparam int unsigned BE_W          = 4;

endpackage

// File: rtl/irqc_src_capture.sv
`timescale 1ns/1ps
module irqc_src_capture #(
    parameter int unsigned NUM_SRC  = 32,
    parameter logic [NUM_SRC-1:0] SRC_KIND = '0
) (
    input  logic [NUM_SRC-1:0] src_now,
    input  logic [NUM_SRC-1:0] src_prev,
    input  logic               cap_en,
    output logic [NUM_SRC-1:0] set_mask
);

    // Per source: level sources pass the input, edge sources detect a rise.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (SRC_KIND[g]) begin : g_edge
            assign set_mask[g] = cap_en & src_now[g] & ~src_prev[g];
        end else begin : g_level
            assign set_mask[g] = cap_en & src_now[g];
        end
    end

endmodule

// File: rtl/irqc_lowest_first.sv
`timescale 1ns/1ps
module irqc_lowest_first #(
    parameter int unsigned N     = 32,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

    // R6: reported index is set and nothing below it is set.
    p_vec_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

    // R6: no request means no valid vector.
    p_vec_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !valid);

endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 6,
    parameter logic [NUM_SRC-1:0] SRC_KIND = 32'hFFFF_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BE_W-1:0]    wr_be,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_out
);

    localparam int unsigned WORD_AW = ADDR_W - 2;
    localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0]  status;
        logic [NUM_SRC-1:0]  enable;
        logic [MASTER_W-1:0] master;
        logic [NUM_SRC-1:0]  prev;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_AW-1:0] word_idx;
    logic               word_mapped;
    logic               acc_aligned;
    logic               wr_ok;
    reg_idx_e           sel;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] cap_set;
    logic [NUM_SRC-1:0] pend;
    logic [IDX_W-1:0]   vec_idx;
    logic               vec_valid;
    logic [DATA_W-1:0]  vec_word;

    // Address decode: full-word, aligned, mapped writes only.
    assign word_idx    = addr[ADDR_W-1:2];
    assign word_mapped = ({{(32-WORD_AW){1'b0}}, word_idx} < 32'(NUM_WORDS));
    assign acc_aligned = (addr[1:0] == 2'b00);
    assign sel         = reg_idx_e'(word_idx[2:0]);
    assign wr_ok       = wr_en && acc_aligned && word_mapped && (wr_be == '1);
    assign wmask       = wdata[NUM_SRC-1:0];

    irqc_src_capture #(
        .NUM_SRC  (NUM_SRC),
        .SRC_KIND (SRC_KIND)
    ) i_capture (
        .src_now  (irq_src),
        .src_prev (st_q.prev),
        .cap_en   (st_q.master[MSTR_CAP_BIT]),
        .set_mask (cap_set)
    );

    assign pend = st_q.status & st_q.enable;

    irqc_lowest_first #(
        .N (NUM_SRC)
    ) i_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pend),
        .idx   (vec_idx),
        .valid (vec_valid)
    );

    assign vec_word = vec_valid ? DATA_W'(vec_idx) : '1;
    assign irq_out  = st_q.master[MSTR_OUT_BIT] && vec_valid;

    // Next-state logic: software write first, then hardware capture on top.
    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_src;
        if (wr_ok) begin
            case (sel)
                RI_STATUS: begin
                    if (!st_q.master[MSTR_CAP_BIT]) begin
                        st_d.status = wmask;
                    end
                end
                RI_ACK:    st_d.status = st_q.status & ~wmask;
                RI_SETEN:  st_d.enable = st_q.enable | wmask;
                RI_CLREN:  st_d.enable = st_q.enable & ~wmask;
                RI_MASTER: st_d.master = wdata[MASTER_W-1:0];
                default: ;
            endcase
        end
        st_d.status = st_d.status | cap_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read path: combinational, zero for write-only and unmapped words.
    always_comb begin
        rdata = '0;
        if (acc_aligned && word_mapped) begin
            case (sel)
                RI_STATUS: rdata = DATA_W'(st_q.status);
                RI_PEND:   rdata = DATA_W'(pend);
                RI_ENABLE: rdata = DATA_W'(st_q.enable);
                RI_VECTOR: rdata = vec_word;
                RI_MASTER: rdata = DATA_W'(st_q.master);
                default:   rdata = '0;
            endcase
        end
    end

    // R4: master word takes the low two written bits.
    p_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_ok && sel == RI_MASTER))
        |-> (st_q.master == $past(wdata[MASTER_W-1:0])));

    // R4: capture off and no status write => status gains no bits.
    p_nocap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(st_q.master[MSTR_CAP_BIT])
         && !$past(wr_ok && sel == RI_STATUS))
        |-> ((st_q.status & ~$past(st_q.status)) == '0));

    // R10: capture on => new status bits come only from capture.
    p_swlock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(st_q.master[MSTR_CAP_BIT]))
        |-> ((st_q.status & ~$past(st_q.status) & ~$past(cap_set)) == '0));

    // R8: acknowledge with capture off leaves masked bits clear.
    p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_ok && sel == RI_ACK)
         && !$past(st_q.master[MSTR_CAP_BIT]))
        |-> ((st_q.status & $past(wmask)) == '0));

    // R9: set-enable leaves all requested bits set.
    p_seten_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_ok && sel == RI_SETEN))
        |-> ((st_q.enable & $past(wmask)) == $past(wmask)));

    // R9: clear-enable leaves all requested bits clear.
    p_clren_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_ok && sel == RI_CLREN))
        |-> ((st_q.enable & $past(wmask)) == '0));

    // R7: request only with something pending and output enabled.
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((pend != '0) && st_q.master[MSTR_OUT_BIT]));

endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;

    localparam logic [31:0] KIND = 32'hFFFF_0000;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_S = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  a;
        logic [3:0]  be;
        logic [31:0] d;
        logic        irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 52;
    localparam vec_t TBL [NV] = '{
        '{OP_W, 6'h1C, 4'hF, 32'hFFFF_FFFF, 1'b0, 8'd4},   // R4 write master
        '{OP_R, 6'h1C, 4'hF, 32'h0000_0003, 1'b0, 8'd4},   // R4 low two bits
        '{OP_S, 6'h00, 4'hF, 32'h0000_0012, 1'b0, 8'd2},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0012, 1'b0, 8'd2},   // R2 level capture
        '{OP_R, 6'h04, 4'hF, 32'h0000_0000, 1'b0, 8'd5},   // R5
        '{OP_R, 6'h18, 4'hF, 32'hFFFF_FFFF, 1'b0, 8'd6},   // R6 none
        '{OP_W, 6'h10, 4'hF, 32'h0000_0010, 1'b0, 8'd9},
        '{OP_R, 6'h08, 4'hF, 32'h0000_0010, 1'b1, 8'd9},   // R9 set-enable
        '{OP_R, 6'h04, 4'hF, 32'h0000_0010, 1'b1, 8'd5},   // R5
        '{OP_R, 6'h18, 4'hF, 32'h0000_0004, 1'b1, 8'd6},   // R6
        '{OP_W, 6'h10, 4'hF, 32'h0000_0002, 1'b0, 8'd9},
        '{OP_R, 6'h18, 4'hF, 32'h0000_0001, 1'b1, 8'd6},   // R6 lowest wins
        '{OP_W, 6'h14, 4'hF, 32'h0000_0002, 1'b0, 8'd9},
        '{OP_R, 6'h08, 4'hF, 32'h0000_0010, 1'b1, 8'd9},   // R9 clear-enable
        '{OP_S, 6'h00, 4'hF, 32'h0000_0000, 1'b0, 8'd2},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0012, 1'b1, 8'd2},   // R2 sticky
        '{OP_W, 6'h0C, 4'hF, 32'h0000_0012, 1'b0, 8'd8},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0000, 1'b0, 8'd8},   // R8 ack
        '{OP_R, 6'h18, 4'hF, 32'hFFFF_FFFF, 1'b0, 8'd6},
        '{OP_S, 6'h00, 4'hF, 32'h0001_0000, 1'b0, 8'd3},
        '{OP_R, 6'h00, 4'hF, 32'h0001_0000, 1'b0, 8'd3},   // R3 edge capture
        '{OP_W, 6'h0C, 4'hF, 32'h0001_0000, 1'b0, 8'd3},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0000, 1'b0, 8'd3},   // R3 held high
        '{OP_S, 6'h00, 4'hF, 32'h0000_0000, 1'b0, 8'd3},
        '{OP_S, 6'h00, 4'hF, 32'h0001_0000, 1'b0, 8'd3},
        '{OP_R, 6'h00, 4'hF, 32'h0001_0000, 1'b0, 8'd3},   // R3 new rise
        '{OP_W, 6'h1C, 4'hF, 32'h0000_0002, 1'b0, 8'd7},
        '{OP_W, 6'h10, 4'hF, 32'h0001_0000, 1'b0, 8'd7},
        '{OP_R, 6'h04, 4'hF, 32'h0001_0000, 1'b0, 8'd7},   // R7 output off
        '{OP_W, 6'h1C, 4'hF, 32'h0000_0000, 1'b0, 8'd10},
        '{OP_W, 6'h00, 4'hF, 32'h0000_0005, 1'b0, 8'd10},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0005, 1'b0, 8'd10},  // R10 sw write
        '{OP_W, 6'h20, 4'hF, 32'hFFFF_FFFF, 1'b0, 8'd11},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0005, 1'b0, 8'd11},  // R11 unmapped write
        '{OP_W, 6'h28, 4'hF, 32'h0000_0000, 1'b0, 8'd11},
        '{OP_R, 6'h08, 4'hF, 32'h0001_0010, 1'b0, 8'd11},  // R11 no alias
        '{OP_W, 6'h1C, 4'hF, 32'h0000_0002, 1'b0, 8'd10},
        '{OP_W, 6'h00, 4'hF, 32'h0000_00F0, 1'b0, 8'd10},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0005, 1'b0, 8'd10},  // R10 locked
        '{OP_R, 6'h0C, 4'hF, 32'h0000_0000, 1'b0, 8'd11},  // R11 zero reads
        '{OP_R, 6'h10, 4'hF, 32'h0000_0000, 1'b0, 8'd11},
        '{OP_R, 6'h14, 4'hF, 32'h0000_0000, 1'b0, 8'd11},
        '{OP_R, 6'h20, 4'hF, 32'h0000_0000, 1'b0, 8'd11},
        '{OP_W, 6'h10, 4'h3, 32'h0000_00FF, 1'b0, 8'd11},
        '{OP_R, 6'h08, 4'hF, 32'h0001_0010, 1'b0, 8'd11},  // R11 partial write
        '{OP_S, 6'h00, 4'hF, 32'h0000_0002, 1'b0, 8'd8},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0007, 1'b0, 8'd8},
        '{OP_W, 6'h0C, 4'hF, 32'h0000_0002, 1'b0, 8'd8},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0007, 1'b0, 8'd8},   // R8 level re-set
        '{OP_S, 6'h00, 4'hF, 32'h0000_0000, 1'b0, 8'd8},
        '{OP_W, 6'h0C, 4'hF, 32'h0000_0007, 1'b0, 8'd8},
        '{OP_R, 6'h00, 4'hF, 32'h0000_0000, 1'b0, 8'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  wr_be = 4'hF;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irqc_top #(
        .NUM_SRC  (32),
        .DATA_W   (32),
        .ADDR_W   (6),
        .SRC_KIND (KIND)
    ) i_irqc_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_src (irq_src),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_be   (wr_be),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_out (irq_out)
    );

    task automatic check(input int rq, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %08h expected %08h", rq, what, got, exp);
        end
    endtask

    // All operations start and end just after a falling edge.
    task automatic do_write(input logic [5:0] a, input logic [31:0] d,
                            input logic [3:0] be);
        addr = a; wdata = d; wr_be = be; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'hF;
    endtask

    task automatic do_src(input logic [31:0] d);
        irq_src = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input int rq, input logic [5:0] a,
                           input logic [31:0] exp, input logic exp_irq);
        addr = a;
        #1;
        check(rq, $sformatf("read %02h", a), rdata, exp);
        check(rq, $sformatf("irq at read %02h", a), {31'd0, irq_out}, {31'd0, exp_irq});
        @(negedge clk);
    endtask

    task automatic reset_checks();
        do_read(1, 6'h00, 32'h0, 1'b0);          // R1 status
        do_read(1, 6'h08, 32'h0, 1'b0);          // R1 enable
        do_read(1, 6'h1C, 32'h0, 1'b0);          // R1 master
        do_read(1, 6'h18, 32'hFFFF_FFFF, 1'b0);  // R1 vector
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_W:    do_write(TBL[i].a, TBL[i].d, TBL[i].be);
                OP_S:    do_src(TBL[i].d);
                default: do_read(int'(TBL[i].req), TBL[i].a, TBL[i].d, TBL[i].irq);
            endcase
        end

        // R6: highest index, capture off, software status write.
        do_write(6'h1C, 32'h0, 4'hF);
        do_write(6'h00, 32'h8000_0000, 4'hF);
        do_write(6'h10, 32'hFFFF_FFFF, 4'hF);
        do_read(6, 6'h18, 32'h0000_001F, 1'b0);

        // R12: output rises only after the edge that takes the write.
        addr = 6'h1C; wdata = 32'h1; wr_be = 4'hF; wr_en = 1'b1;
        #1;
        check(12, "irq before edge", {31'd0, irq_out}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check(12, "irq after edge", {31'd0, irq_out}, 32'd1);

        // R11: misaligned clear-enable is ignored.
        do_write(6'h15, 32'hFFFF_FFFF, 4'hF);
        do_read(11, 6'h08, 32'hFFFF_FFFF, 1'b1);

        // R6: nothing pending again.
        do_write(6'h00, 32'h0, 4'hF);
        do_read(6, 6'h18, 32'hFFFF_FFFF, 1'b0);

        // R1: reset in the middle of a run.
        do_write(6'h00, 32'h0000_0F00, 4'hF);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #20000;
        n_run++;
        n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule